// File: doc/BRIEF.md
# Marker-Synchronized Frame Receiver

This block takes in an unbroken serial stream in which a fixed-length frame of four characters repeats without end, and turns it back into the 32-bit status word the far end sent. Each character is carried in asynchronous serial form and has an extra ninth bit after the eight payload bits. That ninth bit is the only framing information: it is set on the character that opens a frame and clear on the three that follow.

The receiver oversamples the line, finds each start bit, reads the payload and the ninth bit at the centre of their bit cells, and checks the stop bit. A frame-level tracker locks onto the first character whose ninth bit is set. It then collects characters into a holding buffer and publishes the whole word at once, with a one-cycle strobe, when the fourth good character arrives. Frames arrive at a steady rate, so the strobe can serve as a periodic timing tick for logic further down. A wrong ninth bit or a bad stop bit drops the lock, flags the fault for one cycle and discards what was collected.

Top module: `frame_marker_rx`

## Requirements
- R1: While and after reset, with the line idle, `synced`, `word_valid` and `sync_err` are 0 and `word` is all zeros.
- R2: A character is a low start bit, 8 payload bits sent least significant bit first, then the ninth (marker) bit, then a high stop bit, with every bit lasting OVERSAMPLE line samples. Each bit is read on one sample near the centre of its cell.
- R3: While unlocked, characters whose marker is 0 or whose stop bit is low are ignored. A character with marker 1 and a good stop bit sets `synced` to 1 and becomes character 0 of a new frame.
- R4: While locked, the payload of character k (k = 0..3, counted from the marker character) goes to `word[8k+7:8k]`. `word` changes only together with a one-cycle `word_valid` pulse, which follows the fourth character, and only if that character has a good stop bit.
- R5: While locked, a character whose marker differs from the expected value (1 for character 0, 0 for characters 1 to 3) clears `synced`, pulses `sync_err` for one cycle and discards the partial frame. That character does not start a new frame.
- R6: While locked, a character with a low stop bit clears `synced`, pulses `sync_err` for one cycle and discards the partial frame. After a low stop bit, the receiver does not look for a new start bit until the line has gone high again.
- R7: A low pulse on the line that is shorter than half a bit time is not taken as a start bit and produces no character.
- R8: Frames sent back to back, or with idle gaps between characters, keep `synced` at 1 and give exactly one `word_valid` pulse per frame.
- R9: No `sync_err` pulse is produced while unlocked, whatever the characters contain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial line, idle high, asynchronous to clk |
| word | output | DATA_BITS*CHARS_PER_FRAME | Last complete status word |
| word_valid | output | 1 | One-cycle strobe when `word` has been updated |
| synced | output | 1 | Receiver is locked to the frame boundary |
| sync_err | output | 1 | One-cycle pulse when a lock is lost |

## Verification
The hardest cases to reach are faults that arrive while the receiver is already locked and partway through a frame. One such case is a marker that is set where it should be clear on the second character. Another is a low stop bit on the third character, followed by a start bit straight away. The stimulus first locks the receiver with complete frames. It then injects these faults at chosen character positions and checks that the receiver relocks only at the next marker character. For R7, a short glitch is placed exactly at a frame boundary while the receiver is locked: a glitch taken as a start bit would be read as an all-ones character with marker 1, which would turn the next real frame into a marker error.

// File: rtl/frx_pkg.sv
package frx_pkg;

  // Receive states for one serial character
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_BREAK
  } rx_state_e;

endpackage

// File: rtl/frx_tick_gen.sv
module frx_tick_gen #(
  parameter int DIV = 651
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);

  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == W'(DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + W'(1);
      tick <= 1'b0;
    end
  end

endmodule

// File: rtl/frx_char_rx.sv
module frx_char_rx
  import frx_pkg::*;
#(
  parameter int OS = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rxd,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          mark,
  output logic          stop_ok
);

  localparam int SW  = $clog2(OS);
  localparam int MID = OS / 2 - 1;
  localparam int NB  = DW + 1;
  localparam int IW  = $clog2(NB + 1);

  logic [1:0]    meta;
  logic          line;
  rx_state_e     state;
  logic [SW-1:0] scnt;
  logic [IW-1:0] bcnt;
  logic [NB-1:0] shreg;

  // two-flop synchronizer, idle high
  always_ff @(posedge clk) begin
    if (rst) meta <= 2'b11;
    else     meta <= {meta[0], rxd};
  end
  assign line = meta[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RX_IDLE;
      scnt    <= '0;
      bcnt    <= '0;
      shreg   <= '0;
      done    <= 1'b0;
      data    <= '0;
      mark    <= 1'b0;
      stop_ok <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (state)
          RX_IDLE: begin
            if (!line) begin
              state <= RX_START;
              scnt  <= '0;
            end
          end
          RX_START: begin
            if (scnt == SW'(MID)) begin
              scnt <= '0;
              bcnt <= '0;
              state <= line ? RX_IDLE : RX_DATA;
            end else begin
              scnt <= scnt + SW'(1);
            end
          end
          RX_DATA: begin
            if (scnt == SW'(OS - 1)) begin
              scnt  <= '0;
              shreg <= {line, shreg[NB-1:1]};
              if (bcnt == IW'(NB - 1)) state <= RX_STOP;
              else                     bcnt  <= bcnt + IW'(1);
            end else begin
              scnt <= scnt + SW'(1);
            end
          end
          RX_STOP: begin
            if (scnt == SW'(OS - 1)) begin
              scnt    <= '0;
              done    <= 1'b1;
              data    <= shreg[DW-1:0];
              mark    <= shreg[NB-1];
              stop_ok <= line;
              state   <= line ? RX_IDLE : RX_BREAK;
            end else begin
              scnt <= scnt + SW'(1);
            end
          end
          RX_BREAK: begin
            if (line) state <= RX_IDLE;
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/frx_frame_asm.sv
module frx_frame_asm #(
  parameter int DW  = 8,
  parameter int NCH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              char_done,
  input  logic [DW-1:0]     char_data,
  input  logic              char_mark,
  input  logic              char_stop_ok,
  output logic [DW*NCH-1:0] word,
  output logic              word_valid,
  output logic              synced,
  output logic              sync_err
);

  localparam int IXW = $clog2(NCH);
  localparam int PW  = DW * (NCH - 1);

  logic [IXW-1:0] idx;
  logic [PW-1:0]  part;
  logic           exp_mark, fault, lock, take, last;

  always_comb begin
    exp_mark = (idx == '0);
    fault    = char_done && synced &&
               (!char_stop_ok || (char_mark != exp_mark));
    lock     = char_done && !synced && char_mark && char_stop_ok;
    take     = char_done && synced && !fault;
    last     = take && (idx == IXW'(NCH - 1));
  end

  // holding slots for the leading characters of a frame
  genvar k;
  generate
    for (k = 0; k < NCH - 1; k++) begin : g_slot
      logic [DW-1:0] slot;
      logic          load;
      assign load = (k == 0 && lock) ||
                    (take && !last && idx == IXW'(k));
      always_ff @(posedge clk) begin
        if (rst)       slot <= '0;
        else if (load) slot <= char_data;
      end
      assign part[k*DW +: DW] = slot;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      idx        <= '0;
      word       <= '0;
      word_valid <= 1'b0;
      synced     <= 1'b0;
      sync_err   <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      sync_err   <= 1'b0;
      if (lock) begin
        synced <= 1'b1;
        idx    <= IXW'(1);
      end else if (fault) begin
        synced   <= 1'b0;
        sync_err <= 1'b1;
        idx      <= '0;
      end else if (last) begin
        word       <= {char_data, part};
        word_valid <= 1'b1;
        idx        <= '0;
      end else if (take) begin
        idx <= idx + IXW'(1);
      end
    end
  end

endmodule

// File: rtl/frame_marker_rx.sv
module frame_marker_rx #(
  parameter int CLKS_PER_SAMPLE = 651,
  parameter int OVERSAMPLE      = 16,
  parameter int DATA_BITS       = 8,
  parameter int CHARS_PER_FRAME = 4
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 rxd,
  output logic [DATA_BITS*CHARS_PER_FRAME-1:0] word,
  output logic                                 word_valid,
  output logic                                 synced,
  output logic                                 sync_err
);

  logic                 tick;
  logic                 c_done, c_mark, c_stop_ok;
  logic [DATA_BITS-1:0] c_data;

  frx_tick_gen #(.DIV(CLKS_PER_SAMPLE)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  frx_char_rx #(.OS(OVERSAMPLE), .DW(DATA_BITS)) u_char (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .rxd     (rxd),
    .done    (c_done),
    .data    (c_data),
    .mark    (c_mark),
    .stop_ok (c_stop_ok)
  );

  frx_frame_asm #(.DW(DATA_BITS), .NCH(CHARS_PER_FRAME)) u_asm (
    .clk          (clk),
    .rst          (rst),
    .char_done    (c_done),
    .char_data    (c_data),
    .char_mark    (c_mark),
    .char_stop_ok (c_stop_ok),
    .word         (word),
    .word_valid   (word_valid),
    .synced       (synced),
    .sync_err     (sync_err)
  );

endmodule

// File: rtl/frame_marker_rx_chk.sv
module frame_marker_rx_chk #(
  parameter int WW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [WW-1:0] word,
  input logic          word_valid,
  input logic          synced,
  input logic          sync_err
);

  // R4: strobe lasts a single cycle
  a_r4_valid_single: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);

  // R4: published word only moves with the strobe
  a_r4_word_hold: assert property (@(posedge clk) disable iff (rst)
    !word_valid |-> $stable(word));

  // R4: a word is only published while locked throughout
  a_r4_valid_locked: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> (synced && $past(synced)));

  // R5, R6, R9: an error pulse marks the loss of an existing lock
  a_r5_err_drops_lock: assert property (@(posedge clk) disable iff (rst)
    sync_err |-> (!synced && $past(synced)));

  // R6: error pulse is one cycle
  a_r6_err_single: assert property (@(posedge clk) disable iff (rst)
    sync_err |=> !sync_err);

  // R3: gaining lock yields neither a word nor an error
  a_r3_lock_quiet: assert property (@(posedge clk) disable iff (rst)
    $rose(synced) |-> (!word_valid && !sync_err));

endmodule

bind frame_marker_rx frame_marker_rx_chk #(.WW(DATA_BITS*CHARS_PER_FRAME)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .word       (word),
  .word_valid (word_valid),
  .synced     (synced),
  .sync_err   (sync_err)
);

// File: tb/frame_marker_rx_tb.sv
`timescale 1ns/1ps
module frame_marker_rx_tb;

  localparam int DIV      = 2;
  localparam int OS       = 16;
  localparam int BIT_CLKS = DIV * OS;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rxd = 1'b1;
  logic [31:0] word;
  logic        word_valid, synced, sync_err;

  int n_chk = 0, n_fail = 0;
  int valid_cnt = 0, err_cnt = 0;
  logic [31:0] last_word = '0, prev_word = '0;
  bit finished = 0;

  // reference state
  bit   ref_sync = 0;
  logic [7:0] ref_q[$];
  logic [31:0] ref_word = '0;

  always #2.5 clk = ~clk;

  frame_marker_rx #(
    .CLKS_PER_SAMPLE (DIV),
    .OVERSAMPLE      (OS),
    .DATA_BITS       (8),
    .CHARS_PER_FRAME (4)
  ) u_dut (
    .clk        (clk),
    .rst        (rst),
    .rxd        (rxd),
    .word       (word),
    .word_valid (word_valid),
    .synced     (synced),
    .sync_err   (sync_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (word_valid) begin
        valid_cnt++;
        last_word = word;
      end
      if (sync_err) err_cnt++;
      if (!word_valid) chk("R4 word moved without strobe", word, prev_word);
      prev_word = word;
    end
  end

  task automatic send_bit(input logic b);
    rxd = b;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic idle_bits(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  // send one character and compare against the reference model
  task automatic send_char(input logic [7:0] d, input logic mk, input logic good_stop,
                           input string tag);
    int v0, e0, exp_v, exp_e;
    v0 = valid_cnt; e0 = err_cnt; exp_v = 0; exp_e = 0;
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    send_bit(mk);
    send_bit(good_stop);
    if (!good_stop) send_bit(1'b1);
    // reference model
    if (!ref_sync) begin
      if (mk && good_stop) begin
        ref_sync = 1;
        ref_q = {d};
      end
    end else if (!good_stop || (mk != (ref_q.size() == 0))) begin
      ref_sync = 0;
      exp_e = 1;
      ref_q.delete();
    end else begin
      ref_q.push_back(d);
      if (ref_q.size() == 4) begin
        ref_word = {ref_q[3], ref_q[2], ref_q[1], ref_q[0]};
        exp_v = 1;
        ref_q.delete();
      end
    end
    chk({tag, " synced"}, {31'd0, synced}, {31'd0, ref_sync});
    chk({tag, " strobe count"}, valid_cnt - v0, exp_v);
    chk({tag, " error count"}, err_cnt - e0, exp_e);
    if (exp_v != 0) chk({tag, " word"}, last_word, ref_word);
  endtask

  task automatic send_frame(input logic [31:0] w, input int gap, input string tag);
    for (int c = 0; c < 4; c++) begin
      send_char(w[c*8 +: 8], (c == 0), 1'b1, tag);
      if (gap > 0) idle_bits(gap);
    end
  endtask

  initial begin
    repeat (10) @(negedge clk);
    // R1 reset state
    chk("R1 synced in reset", {31'd0, synced}, 32'd0);
    chk("R1 strobe in reset", {31'd0, word_valid}, 32'd0);
    rst = 1'b0;
    idle_bits(2);
    chk("R1 word after reset", word, 32'd0);
    chk("R1 synced after reset", {31'd0, synced}, 32'd0);
    chk("R1 error after reset", {31'd0, sync_err}, 32'd0);

    // R3, R9: unlocked, non-marker and bad-stop characters ignored
    send_char(8'h3C, 1'b0, 1'b1, "R3 unlocked marker0");
    send_char(8'hC3, 1'b1, 1'b0, "R9 unlocked bad stop");
    send_char(8'h00, 1'b0, 1'b0, "R9 unlocked bad stop marker0");

    // R2, R3, R4: lock and assemble
    send_frame(32'h44332211, 0, "R4 first frame");
    // R2 bit order, R8 back to back
    send_frame(32'h80010280, 0, "R2 bit order");
    send_frame(32'h00FF5AA5, 0, "R8 back to back");
    // R8 idle gaps
    send_frame(32'hDEADBEEF, 2, "R8 gapped");

    // R7 short glitch at frame boundary while locked
    rxd = 1'b0;
    repeat (BIT_CLKS / 2 - 2 * DIV - 2) @(negedge clk);
    rxd = 1'b1;
    idle_bits(3);
    chk("R7 glitch no strobe", {31'd0, word_valid}, 32'd0);
    chk("R7 glitch keeps lock", {31'd0, synced}, 32'd1);
    send_frame(32'h12345678, 0, "R7 after glitch");

    // R5 unexpected marker on character 1
    send_char(8'h01, 1'b1, 1'b1, "R5 char0");
    send_char(8'h02, 1'b1, 1'b1, "R5 marker on char1");
    send_char(8'h03, 1'b0, 1'b1, "R5 still unlocked");
    send_frame(32'hCAFEF00D, 0, "R5 relock");

    // R5 missing marker on character 0
    send_char(8'h55, 1'b0, 1'b1, "R5 missing marker");
    send_frame(32'h0BADC0DE, 0, "R5 relock after missing");

    // R6 bad stop on character 2, next start immediately after recovery
    send_char(8'hA1, 1'b1, 1'b1, "R6 char0");
    send_char(8'hA2, 1'b0, 1'b1, "R6 char1");
    send_char(8'hA3, 1'b0, 1'b0, "R6 bad stop char2");
    send_char(8'hA4, 1'b0, 1'b1, "R6 unlocked after fault");
    send_frame(32'h76543210, 0, "R6 relock");

    // R5 marker on character 3
    send_char(8'hB0, 1'b1, 1'b1, "R5 c0");
    send_char(8'hB1, 1'b0, 1'b1, "R5 c1");
    send_char(8'hB2, 1'b0, 1'b1, "R5 c2");
    send_char(8'hB3, 1'b1, 1'b1, "R5 marker on char3");
    chk("R5 word kept after fault", word, 32'h76543210);
    send_frame(32'hFFFFFFFF, 0, "R8 final frame");

    idle_bits(2);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule